// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block decides, at every instruction boundary of an 8-bit CPU core, whether an interrupt is taken and what the response looks like. It watches two request lines. The non-maskable line is active low and edge-triggered. The maskable line is active high and level-sensitive. The block also owns the state that governs acceptance: the two interrupt-enable flip-flops, the response mode register (modes 0, 1 and 2) and the memory-refresh counter.

The core reports each completed instruction, and each completed response, with a one-cycle boundary strobe. In that same cycle it raises the decode pulses for the instruction that is finishing: enable, disable, return-from-interrupt (either flavour) and mode select. It also presents the data-bus byte that the interrupting device supplies, together with a flag that says whether any device drives the bus.

One clock after an accepted boundary, the block pulses the matching acknowledge output. It also presents the total T-state cost of the response, the jump target (or, in mode 2, the table address the core must read), and a halt-exit pulse if the core was halted. Target and cost then hold until the next acceptance.

Top module: `irq_response_seq`

## Requirements
- R1: While rst_n is low at a clock edge, both enable flip-flops clear, the mode becomes 0, the refresh counter becomes 00h, target_addr becomes 0000h, resp_tstates becomes 0, and no acknowledge, vec_fetch or halt_exit pulse is given.
- R2: A high-to-low transition on nmi_n is latched as pending and held until it is accepted. The transition is seen at the clock edge where nmi_n is first sampled low. From the following boundary onward, the NMI is accepted: ack_nmi pulses one cycle after that boundary, target_addr is 0066h, resp_tstates is 11 (a 5-T-state acknowledge plus two 3-T-state writes), and the first enable flip-flop clears while the second keeps its value.
- R3: When a pending NMI and an acceptable maskable request meet at the same boundary, only the NMI is acknowledged.
- R4: At the first boundary after an NMI acceptance, no NMI is accepted, even if a new one is pending. A pending NMI is accepted at the boundary after that.
- R5: The boundary that completes an enable instruction sets both flip-flops but accepts no maskable request. A request can be accepted from the next boundary onward.
- R6: A return-from-interrupt copies the second flip-flop into the first. It blocks maskable acceptance at its own boundary only if the two flip-flops differed before it executed.
- R7: A maskable request is accepted at a boundary when int_req is high, the first flip-flop (after any disable, enable or return in that instruction) is set, and no deferral applies. Acceptance pulses ack_int and clears both flip-flops. Any acceptance while cpu_halted is high also pulses halt_exit.
- R8: In mode 0 the target is the response byte ANDed with 38h, and resp_tstates is 13. If ack_byte_drv is low, the byte is taken as FFh, which gives target 0038h.
- R9: In mode 1 the target is 0038h and resp_tstates is 13, whatever the bus byte.
- R10: In mode 2, vec_fetch pulses with ack_int. target_addr is the I value in bits 15:8 and the response byte in bits 7:0, and resp_tstates is 19.
- R11: The low 7 bits of the refresh counter advance by one for each m1_fetch pulse and by one for each acknowledge, wrapping from 7Fh to 00h, while bit 7 keeps its value. r_load writes r_wdata and takes priority over counting.
- R12: A mode-select decode with im_sel 0, 1 or 2 selects that mode, and the new mode already applies to a request accepted at the same boundary. im_sel 3 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| int_req | input | 1 | Maskable request, active-high level |
| instr_end | input | 1 | Instruction or response boundary strobe |
| cpu_halted | input | 1 | Core is in the halt state |
| m1_fetch | input | 1 | Opcode fetch cycle pulse |
| dec_ei | input | 1 | Enable instruction completes |
| dec_di | input | 1 | Disable instruction completes |
| dec_ret_int | input | 1 | Return-from-interrupt (either form) completes |
| dec_im | input | 1 | Mode-select instruction completes |
| im_sel | input | 2 | Mode requested by dec_im |
| ack_byte | input | 8 | Byte on the data bus during the acknowledge |
| ack_byte_drv | input | 1 | A device drives ack_byte |
| i_reg | input | 8 | Interrupt page register |
| r_load | input | 1 | Write the refresh register |
| r_wdata | input | 8 | Value for r_load |
| iff1 | output | 1 | First enable flip-flop |
| iff2 | output | 1 | Second enable flip-flop |
| int_mode | output | 2 | Current response mode |
| refresh | output | 8 | Refresh counter |
| ack_nmi | output | 1 | NMI acknowledge pulse |
| ack_int | output | 1 | Maskable acknowledge pulse |
| vec_fetch | output | 1 | target_addr is a table address (mode 2) |
| resp_tstates | output | 5 | T-states of the last response |
| target_addr | output | 16 | Jump target or table address |
| halt_exit | output | 1 | Release the halt state |

## Verification
The bench builds the block with its default data width of 8 bits and a 5-bit cost field. With these values every response byte from 00h to FFh can appear in both the mode-0 masking and the mode-2 table address, and the 19-T-state mode-2 cost fits the cost field. The 7-bit refresh count wraps within the random run, both from a loaded value with bit 7 set and from zero. Directed sequences reach the deferral cases: enable, return with unequal flip-flops, and back-to-back NMIs on consecutive boundaries. A long random phase then mixes edges, levels and decode pulses on every clock.

// File: rtl/irq_seq_pkg.sv
// Package: shared constants of the interrupt response sequencer.
// Assumes an 8-bit data path; T-state values are totals per response.
package irq_seq_pkg;

    typedef enum logic [1:0] {
        MODE_RST_BYTE = 2'd0,
        MODE_FIXED    = 2'd1,
        MODE_TABLE    = 2'd2,
        MODE_NONE     = 2'd3
    } resp_mode_e;

    localparam logic [15:0] NMI_TARGET   = 16'h0066;
    localparam logic [15:0] FIXED_TARGET = 16'h0038;
    localparam logic [7:0]  RST_MASK     = 8'h38;
    localparam logic [7:0]  FLOAT_BYTE   = 8'hFF;

    localparam int T_NMI   = 11;
    localparam int T_RST   = 13;
    localparam int T_FIXED = 13;
    localparam int T_TABLE = 19;

endpackage

// File: rtl/irq_enable_ctl.sv
// Module: irq_enable_ctl
// Holds the two enable flip-flops and the response mode. Works out their
// effective values for the instruction that completes at this boundary, and
// whether that instruction defers maskable acceptance.
// Assumes decode pulses are only meaningful together with boundary.
module irq_enable_ctl
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic       ei,
    input  logic       di,
    input  logic       ret_int,
    input  logic       im_wr,
    input  logic [1:0] im_sel,
    input  logic       take_nmi,
    input  logic       take_int,
    output logic       iff1,
    output logic       iff2,
    output resp_mode_e mode,
    output logic       eff_iff1,
    output resp_mode_e eff_mode,
    output logic       defer
);

    logic eff_iff2;

    // Effective flip-flop values and deferral after this instruction's decode.
    always_comb begin
        eff_iff1 = iff1;
        eff_iff2 = iff2;
        defer    = 1'b0;
        if (boundary) begin
            if (ei) begin
                eff_iff1 = 1'b1;
                eff_iff2 = 1'b1;
                defer    = 1'b1;
            end else if (di) begin
                eff_iff1 = 1'b0;
                eff_iff2 = 1'b0;
            end else if (ret_int) begin
                eff_iff1 = iff2;
                defer    = (iff1 != iff2);
            end
        end
    end

    // Effective mode: a valid selection applies at once.
    always_comb begin
        eff_mode = mode;
        if (boundary && im_wr && (im_sel != 2'd3))
            eff_mode = resp_mode_e'(im_sel);
    end

    // State update of flip-flops and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
            mode <= MODE_RST_BYTE;
        end else if (boundary) begin
            mode <= eff_mode;
            if (take_int) begin
                iff1 <= 1'b0;
                iff2 <= 1'b0;
            end else if (take_nmi) begin
                iff1 <= 1'b0;
                iff2 <= eff_iff2;
            end else begin
                iff1 <= eff_iff1;
                iff2 <= eff_iff2;
            end
        end
    end

    // Enable sets both flip-flops unless an NMI is taken at the same boundary.
    p_ei_sets_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && ei && !take_nmi) |=> (iff1 && iff2));

    // A return with differing flip-flops never lets a request through.
    p_ret_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && ret_int && !ei && !di && (iff1 != iff2)) |-> !take_int);

    // A mode-select with code 3 keeps the mode.
    p_im3_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && im_wr && im_sel == 2'd3) |=> $stable(mode));

endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Latches falling edges of the NMI line. Blocks NMI acceptance at the first
// boundary after an NMI response. Decides which request, if any, is taken.
// Assumes nmi_n is already synchronous to clk.
module irq_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic int_req,
    input  logic boundary,
    input  logic eff_iff1,
    input  logic defer,
    output logic take_nmi,
    output logic take_int
);

    logic nmi_n_q;
    logic nmi_fall;
    logic nmi_pend;
    logic nmi_block;

    // Edge detection on the NMI line.
    assign nmi_fall = nmi_n_q & ~nmi_n;

    // Acceptance decisions; NMI wins over a maskable request.
    always_comb begin
        take_nmi = boundary && nmi_pend && !nmi_block;
        take_int = boundary && int_req && eff_iff1 && !defer && !take_nmi;
    end

    // Previous NMI level, pending latch and chaining block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_n_q   <= 1'b1;
            nmi_pend  <= 1'b0;
            nmi_block <= 1'b0;
        end else begin
            nmi_n_q <= nmi_n;
            if (nmi_fall)
                nmi_pend <= 1'b1;
            else if (take_nmi)
                nmi_pend <= 1'b0;
            if (take_nmi)
                nmi_block <= 1'b1;
            else if (boundary)
                nmi_block <= 1'b0;
        end
    end

    // A pending NMI survives a blocked boundary.
    p_pend_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && nmi_pend && nmi_block) |=> nmi_pend);

endmodule

// File: rtl/irq_vector_gen.sv
// Module: irq_vector_gen
// Registers the target and T-state cost of each accepted response.
// Assumes bus_byte already has the floating-bus value substituted.
module irq_vector_gen
    import irq_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 5,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_nmi,
    input  logic          take_int,
    input  resp_mode_e    eff_mode,
    input  logic [DW-1:0] bus_byte,
    input  logic [DW-1:0] i_reg,
    output logic [AW-1:0] target,
    output logic [TW-1:0] cost,
    output logic          vec_fetch
);

    logic [AW-1:0] nxt_target;
    logic [TW-1:0] nxt_cost;
    logic          nxt_vec;

    // Target and cost for the request being taken.
    always_comb begin
        nxt_target = target;
        nxt_cost   = cost;
        nxt_vec    = 1'b0;
        if (take_nmi) begin
            nxt_target = AW'(NMI_TARGET);
            nxt_cost   = TW'(T_NMI);
        end else if (take_int) begin
            unique case (eff_mode)
                MODE_FIXED: begin
                    nxt_target = AW'(FIXED_TARGET);
                    nxt_cost   = TW'(T_FIXED);
                end
                MODE_TABLE: begin
                    nxt_target = {i_reg, bus_byte};
                    nxt_cost   = TW'(T_TABLE);
                    nxt_vec    = 1'b1;
                end
                default: begin
                    nxt_target = AW'(bus_byte & DW'(RST_MASK));
                    nxt_cost   = TW'(T_RST);
                end
            endcase
        end
    end

    // Response result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target    <= '0;
            cost      <= '0;
            vec_fetch <= 1'b0;
        end else begin
            target    <= nxt_target;
            cost      <= nxt_cost;
            vec_fetch <= nxt_vec;
        end
    end

    // Any restart-style target lies on an 8-byte step below 40h.
    p_rst_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && eff_mode == MODE_RST_BYTE) |=> (target[2:0] == 3'd0 && target < AW'(64)));

endmodule

// File: rtl/irq_refresh_ctr.sv
// Module: irq_refresh_ctr
// Refresh counter: the low bits count fetch and acknowledge cycles and the
// top bit is only changed by an explicit load.
module irq_refresh_ctr #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m1_fetch,
    input  logic          ack,
    input  logic          load,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] value
);

    logic [1:0] step;

    // Number of M1 cycles seen this clock.
    assign step = {1'b0, m1_fetch} + {1'b0, ack};

    // Counter update with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (load)
            value <= wdata;
        else
            value[RW-2:0] <= value[RW-2:0] + (RW-1)'(step);
    end

    // Top bit is preserved by counting.
    p_msb_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (value[RW-1] == $past(value[RW-1])));

endmodule

// File: rtl/irq_response_seq.sv
// Module: irq_response_seq (top)
// Interrupt acceptance and response controller. Decisions are made in the
// boundary cycle; acknowledge, target, cost and halt exit appear one clock
// later. Assumes decode pulses and the bus byte accompany instr_end.
module irq_response_seq
    import irq_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 5,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_n,
    input  logic          int_req,
    input  logic          instr_end,
    input  logic          cpu_halted,
    input  logic          m1_fetch,
    input  logic          dec_ei,
    input  logic          dec_di,
    input  logic          dec_ret_int,
    input  logic          dec_im,
    input  logic [1:0]    im_sel,
    input  logic [DW-1:0] ack_byte,
    input  logic          ack_byte_drv,
    input  logic [DW-1:0] i_reg,
    input  logic          r_load,
    input  logic [DW-1:0] r_wdata,
    output logic          iff1,
    output logic          iff2,
    output logic [1:0]    int_mode,
    output logic [DW-1:0] refresh,
    output logic          ack_nmi,
    output logic          ack_int,
    output logic          vec_fetch,
    output logic [TW-1:0] resp_tstates,
    output logic [AW-1:0] target_addr,
    output logic          halt_exit
);

    logic          take_nmi;
    logic          take_int;
    logic          eff_iff1;
    logic          defer;
    resp_mode_e    mode;
    resp_mode_e    eff_mode;
    logic [DW-1:0] bus_byte;

    // Floating bus reads as all ones.
    assign bus_byte = ack_byte_drv ? ack_byte : DW'(FLOAT_BYTE);
    assign int_mode = mode;

    irq_enable_ctl u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (instr_end),
        .ei       (dec_ei),
        .di       (dec_di),
        .ret_int  (dec_ret_int),
        .im_wr    (dec_im),
        .im_sel   (im_sel),
        .take_nmi (take_nmi),
        .take_int (take_int),
        .iff1     (iff1),
        .iff2     (iff2),
        .mode     (mode),
        .eff_iff1 (eff_iff1),
        .eff_mode (eff_mode),
        .defer    (defer)
    );

    irq_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_n    (nmi_n),
        .int_req  (int_req),
        .boundary (instr_end),
        .eff_iff1 (eff_iff1),
        .defer    (defer),
        .take_nmi (take_nmi),
        .take_int (take_int)
    );

    irq_vector_gen #(.DW(DW), .TW(TW)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_nmi  (take_nmi),
        .take_int  (take_int),
        .eff_mode  (eff_mode),
        .bus_byte  (bus_byte),
        .i_reg     (i_reg),
        .target    (target_addr),
        .cost      (resp_tstates),
        .vec_fetch (vec_fetch)
    );

    irq_refresh_ctr #(.RW(DW)) u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .m1_fetch (m1_fetch),
        .ack      (take_nmi | take_int),
        .load     (r_load),
        .wdata    (r_wdata),
        .value    (refresh)
    );

    // Acknowledge and halt-exit pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_nmi   <= 1'b0;
            ack_int   <= 1'b0;
            halt_exit <= 1'b0;
        end else begin
            ack_nmi   <= take_nmi;
            ack_int   <= take_int;
            halt_exit <= (take_nmi | take_int) & cpu_halted;
        end
    end

    p_single_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_nmi, ack_int}));

    p_nmi_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |=> !ack_nmi);

    p_nmi_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |-> (!iff1 && target_addr == AW'(NMI_TARGET)));

    p_int_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |-> (!iff1 && !iff2));

    p_table_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch |-> (ack_int && resp_tstates == TW'(T_TABLE)));

    p_halt_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_exit |-> (ack_nmi || ack_int));

endmodule

// File: tb/irq_response_seq_tb.sv
`timescale 1ns/1ps
module irq_response_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       nmi_n, int_req, instr_end, cpu_halted, m1_fetch;
    logic       dec_ei, dec_di, dec_ret_int, dec_im;
    logic [1:0] im_sel;
    logic [7:0] ack_byte, i_reg, r_wdata;
    logic       ack_byte_drv, r_load;
    logic       iff1, iff2, ack_nmi, ack_int, vec_fetch, halt_exit;
    logic [1:0] int_mode;
    logic [7:0] refresh;
    logic [4:0] resp_tstates;
    logic [15:0] target_addr;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_response_seq u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_req(int_req),
        .instr_end(instr_end), .cpu_halted(cpu_halted), .m1_fetch(m1_fetch),
        .dec_ei(dec_ei), .dec_di(dec_di), .dec_ret_int(dec_ret_int),
        .dec_im(dec_im), .im_sel(im_sel), .ack_byte(ack_byte),
        .ack_byte_drv(ack_byte_drv), .i_reg(i_reg), .r_load(r_load),
        .r_wdata(r_wdata), .iff1(iff1), .iff2(iff2), .int_mode(int_mode),
        .refresh(refresh), .ack_nmi(ack_nmi), .ack_int(ack_int),
        .vec_fetch(vec_fetch), .resp_tstates(resp_tstates),
        .target_addr(target_addr), .halt_exit(halt_exit)
    );

    // Behavioural reference state.
    bit    m_iff1, m_iff2, m_nq, m_pend, m_block, m_ackn, m_acki, m_vec, m_halt;
    int    m_mode, m_tgt, m_cost, m_rlow, m_rmsb;
    string m_tag = "R1";

    always @(posedge clk) begin
        bit fall, e1, e2, dfr, tn, ti;
        int em, byte_v;
        if (!rst_n) begin
            m_iff1 = 0; m_iff2 = 0; m_nq = 1; m_pend = 0; m_block = 0;
            m_ackn = 0; m_acki = 0; m_vec = 0; m_halt = 0;
            m_mode = 0; m_tgt = 0; m_cost = 0; m_rlow = 0; m_rmsb = 0;
            m_tag = "R1";
        end else begin
            fall = m_nq && !nmi_n;
            m_nq = nmi_n;
            e1 = m_iff1; e2 = m_iff2; em = m_mode; dfr = 0;
            if (instr_end) begin
                if (dec_ei) begin e1 = 1; e2 = 1; dfr = 1; end
                else if (dec_di) begin e1 = 0; e2 = 0; end
                else if (dec_ret_int) begin dfr = (m_iff1 != m_iff2); e1 = m_iff2; end
                if (dec_im && im_sel != 2'd3) em = im_sel;
            end
            tn = instr_end && m_pend && !m_block;
            ti = instr_end && int_req && e1 && !dfr && !tn;
            if (fall) m_pend = 1; else if (tn) m_pend = 0;
            if (tn) m_block = 1; else if (instr_end) m_block = 0;
            if (instr_end) begin
                m_mode = em;
                if (ti) begin m_iff1 = 0; m_iff2 = 0; end
                else if (tn) begin m_iff1 = 0; m_iff2 = e2; end
                else begin m_iff1 = e1; m_iff2 = e2; end
            end
            if (r_load) begin m_rlow = r_wdata & 8'h7F; m_rmsb = r_wdata[7]; end
            else m_rlow = (m_rlow + int'(m1_fetch) + int'(tn || ti)) % 128;
            byte_v = ack_byte_drv ? int'(ack_byte) : 255;
            m_vec = 0;
            if (tn) begin m_tgt = 16'h0066; m_cost = 11; m_tag = "R2"; end
            else if (ti) begin
                if (em == 1) begin m_tgt = 16'h0038; m_cost = 13; m_tag = "R9"; end
                else if (em == 2) begin m_tgt = int'(i_reg) * 256 + byte_v; m_cost = 19; m_vec = 1; m_tag = "R10"; end
                else begin m_tgt = byte_v & 8'h38; m_cost = 13; m_tag = "R8"; end
            end
            m_ackn = tn; m_acki = ti;
            m_halt = (tn || ti) && cpu_halted;
        end
    end

    task automatic cmp(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output with the reference.
    task automatic check_all();
        cmp("R7", "iff1", int'(iff1), int'(m_iff1));
        cmp("R6", "iff2", int'(iff2), int'(m_iff2));
        cmp("R12", "int_mode", int'(int_mode), m_mode);
        cmp("R11", "refresh", int'(refresh), m_rmsb * 128 + m_rlow);
        cmp("R2", "ack_nmi", int'(ack_nmi), int'(m_ackn));
        cmp("R7", "ack_int", int'(ack_int), int'(m_acki));
        cmp("R10", "vec_fetch", int'(vec_fetch), int'(m_vec));
        cmp(m_tag, "target_addr", int'(target_addr), m_tgt);
        cmp(m_tag, "resp_tstates", int'(resp_tstates), m_cost);
        cmp("R7", "halt_exit", int'(halt_exit), int'(m_halt));
    endtask

    task automatic tick();
        @(negedge clk);
        check_all();
        instr_end = 0; dec_ei = 0; dec_di = 0; dec_ret_int = 0; dec_im = 0;
        r_load = 0; m1_fetch = 0;
    endtask

    task automatic bnd();
        instr_end = 1;
        tick();
    endtask

    initial begin
        rst_n = 0; nmi_n = 1; int_req = 0; instr_end = 0; cpu_halted = 0;
        m1_fetch = 0; dec_ei = 0; dec_di = 0; dec_ret_int = 0; dec_im = 0;
        im_sel = 0; ack_byte = 0; ack_byte_drv = 0; i_reg = 0; r_load = 0;
        r_wdata = 0;
        // R1: reset state checked on each reset cycle
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R5: EI boundary with request high takes nothing; next boundary takes it.
        // R8: undriven bus gives 0038h.
        int_req = 1; dec_ei = 1; bnd();
        bnd(); tick();
        // R12 and R10: select mode 2 at the same boundary as the request.
        dec_ei = 1; bnd();
        dec_im = 1; im_sel = 2; i_reg = 8'h12; ack_byte = 8'h40; ack_byte_drv = 1;
        bnd(); tick();
        // R3: NMI and maskable request at the same boundary.
        dec_ei = 1; bnd(); tick();
        nmi_n = 0; tick(); nmi_n = 1; tick();
        bnd(); tick();
        // R4: new edge right after, consecutive boundaries.
        int_req = 0;
        nmi_n = 0; tick(); nmi_n = 1;
        bnd(); bnd(); bnd(); tick();
        // R6: return with differing flip-flops (after EI then NMI).
        dec_ei = 1; bnd(); bnd();
        nmi_n = 0; tick(); nmi_n = 1; bnd(); tick();
        int_req = 1; dec_ret_int = 1; bnd(); bnd(); tick();
        // R6: return with equal flip-flops does not defer.
        int_req = 0; dec_ei = 1; bnd(); bnd();
        int_req = 1; dec_ret_int = 1; bnd(); tick();
        // R9 and R12: mode 1, then im_sel 3 ignored; R7 halt exit.
        int_req = 0; dec_im = 1; im_sel = 1; bnd();
        dec_im = 1; im_sel = 3; bnd();
        dec_ei = 1; bnd();
        ack_byte = 8'hD7; cpu_halted = 1; int_req = 1; bnd(); tick();
        // R8: mode 0 restart byte D7h -> 0010h; R7 DI blocks acceptance.
        dec_im = 1; im_sel = 0; dec_ei = 1; bnd();
        dec_di = 1; bnd(); bnd();
        dec_ei = 1; bnd(); bnd(); tick();
        cpu_halted = 0; int_req = 0;
        // R11: load with bit 7 set, count through the wrap.
        r_load = 1; r_wdata = 8'hFD; tick();
        for (int k = 0; k < 6; k++) begin m1_fetch = 1; tick(); end
        // Random phase covering all requirements together.
        for (int k = 0; k < 6000; k++) begin
            instr_end    = ($urandom % 2) == 0;
            m1_fetch     = ($urandom % 3) == 0;
            int_req      = ($urandom % 4) != 0 ? int_req : ~int_req;
            if (($urandom % 16) == 0) nmi_n = ~nmi_n;
            cpu_halted   = ($urandom % 5) == 0;
            dec_ei       = ($urandom % 8) == 0;
            dec_di       = ($urandom % 12) == 0;
            dec_ret_int  = ($urandom % 8) == 0;
            dec_im       = ($urandom % 10) == 0;
            im_sel       = 2'($urandom);
            ack_byte     = 8'($urandom);
            ack_byte_drv = ($urandom % 4) != 0;
            i_reg        = 8'($urandom);
            r_load       = ($urandom % 200) == 0;
            r_wdata      = 8'($urandom);
            if (($urandom % 500) == 0) rst_n = 0; else rst_n = 1;
            @(negedge clk);
            check_all();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule